// File: doc/BRIEF.md
# Latched Inter-Processor Interrupt Generator

This block lets any of five processors raise a software interrupt on any processor in the group, itself included. Each processor owns one generation register. Writing a word to it names a destination processor and a 3-bit interrupt identifier. The destination then records a pending bit for that identifier, and the bit stays set until the destination clears it.

Each destination holds an 8-bit pending vector, one bit per identifier value. The destination reads the vector and clears bits by writing ones to its clear register. Each processor has one interrupt line. The line is high while any pending bit that its 8-bit mask lets through is set. A write that names a processor outside the group changes no pending bit and raises a sticky error flag.

Top module: `ipi_latch_gen`

## Requirements
- R1: While reset is asserted (rst_n low), every pending bit reads 0, every interrupt line is 0 and the error flag is 0.
- R2: A generation write sets pending bit ID of destination TGT. In the write word, ID is bits [2:0] and TGT is bits [6:4]; bits 3 and 7 have no effect. The bit reads as set from the first clock edge after the write.
- R3: Writes from several senders in the same cycle all take effect. Their pending bits are ORed into the destination vectors.
- R4: A pending bit stays set across any number of idle cycles until a clear removes it.
- R5: A clear write with clr_we high clears, at the next edge, each pending bit of that processor whose data bit is 1. Bits written as 0 are unchanged. Clear data has no effect while clr_we is low.
- R6: When a set and a clear reach the same pending bit in the same cycle, the bit is set after the edge.
- R7: A write whose TGT field is 5, 6 or 7 changes no pending bit. It sets tgt_err at the next edge, and tgt_err stays set until reset.
- R8: The interrupt line of processor t is the OR of its pending vector ANDed with irq_mask bits [8t+7:8t]. The line follows the pending bits and the mask with no added clock delay.
- R9: A processor that writes its own number into TGT gets the same pending bit and interrupt as it would from any other sender.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gen_we | input | 5 | Generation-register write strobe, one per sender |
| gen_wdata | input | 40 | Generation write words, 8 bits per sender (sender s at [8s+7:8s]) |
| clr_we | input | 5 | Clear-register write strobe, one per processor |
| clr_data | input | 40 | Write-one-to-clear data, 8 bits per processor |
| irq_mask | input | 40 | Interrupt enable mask, 8 bits per processor |
| pend | output | 40 | Pending vectors, 8 bits per processor |
| irq | output | 5 | Interrupt line per processor |
| tgt_err | output | 1 | Sticky flag for a write that names a processor outside the group |

## Verification
The pending vectors and the error flag change one rising edge after the write that affects them. The interrupt lines are combinational from the pending vectors and the mask, so a line changes in the same cycle as the pending bits or the mask that drive it. The bench drives every stimulus on a falling edge and holds the strobes for exactly one rising edge. It samples on the next falling edge, which is the first point where a registered result can be seen and well before the edge after it.

// File: rtl/ipi_latch_gen.sv
module ipi_latch_gen #(
  parameter int NPROC   = 5,
  parameter int IDW     = 3,
  parameter int TGTW    = 3,
  parameter int WORDW   = 8,
  parameter int TGT_LSB = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPROC-1:0]       gen_we,
  input  logic [NPROC*WORDW-1:0] gen_wdata,
  input  logic [NPROC-1:0]       clr_we,
  input  logic [NPROC*(1<<IDW)-1:0] clr_data,
  input  logic [NPROC*(1<<IDW)-1:0] irq_mask,
  output logic [NPROC*(1<<IDW)-1:0] pend,
  output logic [NPROC-1:0]       irq,
  output logic                   tgt_err
);

  localparam int NID = 1 << IDW;

  logic [NID-1:0] pend_q [NPROC];
  logic [NID-1:0] set_v  [NPROC];
  logic           bad_wr;
  logic           err_q;

  always_comb begin
    bad_wr = 1'b0;
    for (int t = 0; t < NPROC; t++) set_v[t] = '0;
    for (int s = 0; s < NPROC; s++) begin
      if (gen_we[s]) begin
        if (int'(gen_wdata[s*WORDW+TGT_LSB +: TGTW]) >= NPROC) bad_wr = 1'b1;
        for (int t = 0; t < NPROC; t++)
          if (gen_wdata[s*WORDW+TGT_LSB +: TGTW] == TGTW'(t))
            set_v[t][gen_wdata[s*WORDW +: IDW]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_q | bad_wr;
  end

  assign tgt_err = err_q;

  for (genvar t = 0; t < NPROC; t++) begin : g_tgt
    logic [NID-1:0] clr_m;
    assign clr_m = clr_we[t] ? clr_data[t*NID +: NID] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[t] <= '0;
      else        pend_q[t] <= (pend_q[t] & ~clr_m) | set_v[t];
    end

    assign pend[t*NID +: NID] = pend_q[t];
    assign irq[t] = |(pend_q[t] & irq_mask[t*NID +: NID]);

    for (genvar b = 0; b < NID; b++) begin : g_bit
      p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        set_v[t][b] |=> pend_q[t][b]);
      p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q[t][b] && !set_v[t][b]) |=> !pend_q[t][b]);
      p_latched_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q[t][b] && !(clr_we[t] && clr_data[t*NID+b])) |=> pend_q[t][b]);
      p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we[t] && clr_data[t*NID+b] && !set_v[t][b]) |=> !pend_q[t][b]);
    end
  end

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_err |=> tgt_err);
  p_err_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_err) |-> $past(bad_wr));

endmodule

// File: tb/test_ipi_latch_gen.sv
module test_ipi_latch_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  gen_we;
  logic [39:0] gen_wdata;
  logic [4:0]  clr_we;
  logic [39:0] clr_data;
  logic [39:0] irq_mask;
  logic [39:0] pend;
  logic [4:0]  irq;
  logic        tgt_err;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ipi_latch_gen i_ipi_latch_gen (
    .clk(clk), .rst_n(rst_n), .gen_we(gen_we), .gen_wdata(gen_wdata),
    .clr_we(clr_we), .clr_data(clr_data), .irq_mask(irq_mask),
    .pend(pend), .irq(irq), .tgt_err(tgt_err));

  // {sender[2:0], word[7:0], target[2:0], expected target pending[7:0]}
  localparam logic [21:0] VEC [8] = '{
    {3'd0, 8'h13, 3'd1, 8'h08},
    {3'd2, 8'h10, 3'd1, 8'h09},
    {3'd4, 8'h27, 3'd2, 8'h80},
    {3'd1, 8'h40, 3'd4, 8'h01},
    {3'd3, 8'h33, 3'd3, 8'h08},   // R9 self target
    {3'd0, 8'h95, 3'd1, 8'h29},   // bit 7 ignored (R2)
    {3'd1, 8'h13, 3'd1, 8'h29},
    {3'd2, 8'h02, 3'd0, 8'h04}
  };

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    gen_we = '0; gen_wdata = '0; clr_we = '0; clr_data = '0;
  endtask

  task automatic step();
    @(negedge clk);
    idle();
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    idle();
    irq_mask = '1;
    repeat (2) @(negedge clk);
    chk("R1 pend", pend, '0);
    chk("R1 irq", 40'(irq), '0);
    chk("R1 err", 40'(tgt_err), '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      gen_we[VEC[i][21:19]] = 1'b1;
      gen_wdata[VEC[i][21:19]*8 +: 8] = VEC[i][18:11];
      step();
      chk("R2/R9 pend", 40'(pend[VEC[i][10:8]*8 +: 8]), 40'(VEC[i][7:0]));
      chk("R8 irq", 40'(irq[VEC[i][10:8]]), 40'd1);
    end
    chk("R2 no err", 40'(tgt_err), '0);

    repeat (3) @(negedge clk);
    chk("R4 hold", 40'(pend[15:8]), 40'h29);

    gen_we = 5'b00011; gen_wdata[7:0] = 8'h05; gen_wdata[15:8] = 8'h06;
    step();
    chk("R3 multi", 40'(pend[7:0]), 40'h64);

    clr_we = '0; clr_data[7:0] = 8'hFF;
    step();
    chk("R5 no strobe", 40'(pend[7:0]), 40'h64);

    clr_we[0] = 1'b1; clr_data[7:0] = 8'h24;
    step();
    chk("R5 w1c", 40'(pend[7:0]), 40'h40);
    chk("R5 others", 40'(pend[15:8]), 40'h29);

    gen_we[2] = 1'b1; gen_wdata[23:16] = 8'h01;
    clr_we[0] = 1'b1; clr_data[7:0] = 8'h42;
    step();
    chk("R6 set wins", 40'(pend[7:0]), 40'h02);

    gen_we[4] = 1'b1; gen_wdata[39:32] = 8'h51;
    step();
    chk("R7 err", 40'(tgt_err), 40'd1);
    chk("R7 no change", pend, 40'h01_08_80_29_02);
    gen_we[1] = 1'b1; gen_wdata[15:8] = 8'h74;
    step();
    chk("R7 tgt7 ignored", pend, 40'h01_08_80_29_02);
    gen_we[0] = 1'b1; gen_wdata[7:0] = 8'h43;
    step();
    repeat (2) @(negedge clk);
    chk("R7 sticky", 40'(tgt_err), 40'd1);
    chk("R2 after err", 40'(pend[39:32]), 40'h09);

    irq_mask[7:0] = 8'h00;
    @(negedge clk);
    chk("R8 masked", 40'(irq[0]), 40'd0);
    irq_mask[7:0] = 8'h02;
    @(negedge clk);
    chk("R8 enabled", 40'(irq[0]), 40'd1);
    irq_mask[7:0] = 8'hFD;
    @(negedge clk);
    chk("R8 other bits", 40'(irq[0]), 40'd0);
    chk("R8 irq1", 40'(irq[1]), 40'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule